// File: doc/BRIEF.md
# Shared Mailbox Bank with Level Interrupts

This block holds a small bank of single-slot mailboxes, each passing one 32-bit message from a producing agent to a consuming agent. The slot's own top bit is its occupancy flag. A producer posts a message by writing the payload with that bit set. A consumer takes the message by reading the slot, then releases the slot by writing zero to it. Each slot has two gate bits, one for its full condition and one for its empty condition. The gated conditions of all slots meet in one read-only status word.

A set of interrupt lines, each with its own enable word laid out like the status word, turns the status into level-sensitive requests. A line stays high for as long as any enabled condition holds. An enabled empty condition therefore keeps firing while a slot is idle, so a producer normally opens its empty gate only after posting. A read-only sizing word reports how many slots and lines the bank has.

The register port is a plain single-cycle write strobe with a combinational read path. It has no handshake, and every access completes in the cycle it is presented.

Top module: `mbx_bank`

## Requirements
- R1: After reset every slot word, every gate bit and every line enable word reads zero, and all interrupt outputs are low.
- R2: A write to slot i (word address 4*i) stores the whole 32-bit value. When bit 31 of the value is 1, the slot is full.
- R3: Writing zero to a slot word clears the payload and its bit 31, so the slot reads empty.
- R4: The status word (address 32) carries, for each slot i, the bit empty_i AND empty-gate_i at bit i and the bit full_i AND full-gate_i at bit 8+i. Bits for slots that are not present and bits 31:16 read zero.
- R5: Writes to the status word have no effect on it or on any slot.
- R6: Interrupt line k is a register that takes the OR of (status AND enable word k) one clock after the change. Enable word k is at address 40+k.
- R7: Interrupts are levels. An enabled condition keeps its line high for as long as it lasts, with no pulse or self-clear.
- R8: The sizing word (address 33) reads slot count in bits 3:0 and line count in bits 19:16, and zero elsewhere. Writes to it are ignored.
- R9: The full gate of slot i is bit 0 of address 4*i+1 and its empty gate is bit 0 of address 4*i+2. Both are readable, and clearing a gate removes that condition from the status word and from the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W | Word address of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| irq | output | N_LINES | Level interrupt lines, registered |

## Verification
The assertions assume that reset is applied from time zero, that reg_wr is never X once reset is released, and that an address is held steady for the whole cycle of its write strobe. The stimulus drives every input on the falling edge, so each write strobe spans exactly one rising edge. Reset is asserted at the start and again near the end of the run. The bench samples reads and interrupt lines only between edges.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int SLOT_STRIDE = 4;   // word, full gate, empty gate, spare
  localparam int OFS_WORD    = 0;
  localparam int OFS_FGATE   = 1;
  localparam int OFS_EGATE   = 2;
  localparam int STAT_ADDR   = 32;
  localparam int SIZE_ADDR   = 33;
  localparam int LINE_BASE   = 40;
  localparam int STAT_W      = 16;  // 8 empty bits, 8 full bits
  localparam int FULL_OFS    = 8;

  function automatic logic [31:0] size_word(input int n_slots, input int n_lines);
    logic [31:0] w;
    w        = '0;
    w[3:0]   = 4'(n_slots);
    w[19:16] = 4'(n_lines);
    return w;
  endfunction
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_word,
  input  logic          wr_fgate,
  input  logic          wr_egate,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] word_q,
  output logic          fgate_q,
  output logic          egate_q,
  output logic          full_cond,
  output logic          empty_cond
);
  localparam int FLAG = DW - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      fgate_q <= 1'b0;
      egate_q <= 1'b0;
    end else begin
      if (wr_word)  word_q  <= wdata;
      if (wr_fgate) fgate_q <= wdata[0];
      if (wr_egate) egate_q <= wdata[0];
    end
  end

  always_comb begin
    full_cond  = word_q[FLAG] & fgate_q;
    empty_cond = ~word_q[FLAG] & egate_q;
  end
endmodule

// File: rtl/mbx_irq_line.sv
module mbx_irq_line #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_wr,
  input  logic [SW-1:0] en_wdata,
  input  logic [SW-1:0] valid_mask,
  input  logic [SW-1:0] status,
  output logic [SW-1:0] en_q,
  output logic          irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_wr) en_q <= en_wdata & valid_mask;
      irq_q <= |(status & en_q);
    end
  end
endmodule

// File: rtl/mbx_bank.sv
module mbx_bank
  import mbx_pkg::*;
#(
  parameter int N_MBOX  = 4,
  parameter int N_LINES = 2,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [N_LINES-1:0] irq
);
  localparam int DW = 32;
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] A_SIZE = ADDR_W'(SIZE_ADDR);
  localparam logic [31:0]       SIZE_VAL = size_word(N_MBOX, N_LINES);

  logic [N_MBOX-1:0][DW-1:0]      slot_word;
  logic [N_MBOX-1:0]              fgate, egate, full_c, empty_c;
  logic [STAT_W-1:0]              status_w, valid_mask;
  logic [N_LINES-1:0][STAT_W-1:0] en_q;

  for (genvar i = 0; i < N_MBOX; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] A_W = ADDR_W'(i*SLOT_STRIDE + OFS_WORD);
    localparam logic [ADDR_W-1:0] A_F = ADDR_W'(i*SLOT_STRIDE + OFS_FGATE);
    localparam logic [ADDR_W-1:0] A_E = ADDR_W'(i*SLOT_STRIDE + OFS_EGATE);
    mbx_slot #(.DW(DW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_word   (reg_wr && reg_addr == A_W),
      .wr_fgate  (reg_wr && reg_addr == A_F),
      .wr_egate  (reg_wr && reg_addr == A_E),
      .wdata     (reg_wdata),
      .word_q    (slot_word[i]),
      .fgate_q   (fgate[i]),
      .egate_q   (egate[i]),
      .full_cond (full_c[i]),
      .empty_cond(empty_c[i])
    );
  end

  always_comb begin
    status_w   = '0;
    valid_mask = '0;
    for (int i = 0; i < N_MBOX; i++) begin
      status_w[i]            = empty_c[i];
      status_w[FULL_OFS + i] = full_c[i];
      valid_mask[i]            = 1'b1;
      valid_mask[FULL_OFS + i] = 1'b1;
    end
  end

  for (genvar k = 0; k < N_LINES; k++) begin : g_line
    localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(LINE_BASE + k);
    mbx_irq_line #(.SW(STAT_W)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_wr     (reg_wr && reg_addr == A_EN),
      .en_wdata  (reg_wdata[STAT_W-1:0]),
      .valid_mask(valid_mask),
      .status    (status_w),
      .en_q      (en_q[k]),
      .irq_q     (irq[k])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_STAT) reg_rdata = {{(32-STAT_W){1'b0}}, status_w};
    if (reg_addr == A_SIZE) reg_rdata = SIZE_VAL;
    for (int i = 0; i < N_MBOX; i++) begin
      if (reg_addr == ADDR_W'(i*SLOT_STRIDE + OFS_WORD))  reg_rdata = slot_word[i];
      if (reg_addr == ADDR_W'(i*SLOT_STRIDE + OFS_FGATE)) reg_rdata = {31'b0, fgate[i]};
      if (reg_addr == ADDR_W'(i*SLOT_STRIDE + OFS_EGATE)) reg_rdata = {31'b0, egate[i]};
    end
    for (int k = 0; k < N_LINES; k++) begin
      if (reg_addr == ADDR_W'(LINE_BASE + k)) reg_rdata = {{(32-STAT_W){1'b0}}, en_q[k]};
    end
  end
endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
  parameter int N_MBOX  = 4,
  parameter int N_LINES = 2,
  parameter int ADDR_W  = 6
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           reg_wr,
  input logic [ADDR_W-1:0]              reg_addr,
  input logic [31:0]                    reg_wdata,
  input logic [N_MBOX-1:0][31:0]        slot_word,
  input logic [15:0]                    status,
  input logic [N_LINES-1:0][15:0]       en,
  input logic [N_LINES-1:0]             irq
);
  // R1: a cycle spent in reset leaves every line low
  p_irq_low_after_reset_r1: assert property (@(posedge clk) !rst_n |=> irq == '0);

  // R5: a write aimed at the status word leaves every slot untouched
  p_status_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(32)) |=> $stable(slot_word));

  for (genvar i = 0; i < N_MBOX; i++) begin : g_slot_chk
    // R2: a posted word with the flag set leaves the slot full
    p_post_sets_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(4*i) && reg_wdata[31]) |=> slot_word[i][31]);
    // R3: writing zero empties the slot completely
    p_zero_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(4*i) && reg_wdata == '0) |=> slot_word[i] == '0);
    // R4: a slot never reports both empty and full
    p_empty_full_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({status[i], status[8+i]}) <= 1);
  end

  for (genvar k = 0; k < N_LINES; k++) begin : g_line_chk
    // R6: each line follows the enabled status one clock later
    p_line_tracks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq[k] == $past(|(status & en[k])));
  end
endmodule

bind mbx_bank mbx_bank_chk #(.N_MBOX(N_MBOX), .N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .slot_word(slot_word),
  .status   (status_w),
  .en       (en_q),
  .irq      (irq)
);

// File: tb/mbx_bank_test.sv
module mbx_bank_test;
  localparam int N_MBOX = 4, N_LINES = 2, ADDR_W = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N_LINES-1:0] irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  mbx_bank #(.N_MBOX(N_MBOX), .N_LINES(N_LINES), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [5:0]  a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 6'd0,  32'h0000_0000, 4'd1},  // R1 slot 0 empty
    '{1'b0, 6'd32, 32'h0000_0000, 4'd1},  // R1 status zero
    '{1'b0, 6'd40, 32'h0000_0000, 4'd1},  // R1 line enable zero
    '{1'b0, 6'd33, 32'h0002_0004, 4'd8},  // R8 sizing word
    '{1'b1, 6'd1,  32'h0000_0001, 4'd0},
    '{1'b1, 6'd2,  32'h0000_0001, 4'd0},
    '{1'b0, 6'd1,  32'h0000_0001, 4'd9},  // R9 gate readback
    '{1'b0, 6'd32, 32'h0000_0001, 4'd4},  // R4 empty bit 0
    '{1'b1, 6'd0,  32'h8000_1234, 4'd0},
    '{1'b0, 6'd0,  32'h8000_1234, 4'd2},  // R2 payload kept
    '{1'b0, 6'd32, 32'h0000_0100, 4'd2},  // R2 full bit 8
    '{1'b1, 6'd32, 32'h0000_FFFF, 4'd0},
    '{1'b0, 6'd32, 32'h0000_0100, 4'd5},  // R5 status write ignored
    '{1'b1, 6'd0,  32'h0000_0000, 4'd0},
    '{1'b0, 6'd0,  32'h0000_0000, 4'd3},  // R3 slot cleared
    '{1'b0, 6'd32, 32'h0000_0001, 4'd3},  // R3 empty again
    '{1'b1, 6'd13, 32'h0000_0001, 4'd0},
    '{1'b1, 6'd12, 32'h8000_00AA, 4'd0},
    '{1'b0, 6'd32, 32'h0000_0801, 4'd4},  // R4 slot 3 full bit 11
    '{1'b1, 6'd33, 32'h0000_0000, 4'd0},
    '{1'b0, 6'd33, 32'h0002_0004, 4'd8},  // R8 read-only
    '{1'b1, 6'd14, 32'h0000_0001, 4'd0},
    '{1'b0, 6'd32, 32'h0000_0801, 4'd4},  // R4 empty gated by full
    '{1'b1, 6'd12, 32'h0000_0000, 4'd0},
    '{1'b0, 6'd32, 32'h0000_0009, 4'd4}   // R4 bits 3 and 0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_chk(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 irq", {30'b0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v].wr) write(VEC[v].a, VEC[v].d);
      else begin
        @(negedge clk);
        read_chk(VEC[v].a, VEC[v].d, $sformatf("R%0d vec%0d", VEC[v].req, v));
      end
    end

    // R6: line 0 enabled on slot 0 empty; rises one clock after the enable lands
    write(6'd40, 32'h0000_0001);
    check("R6 latency", {30'b0, irq}, 32'h0);
    @(negedge clk);
    check("R6 line0 up", {30'b0, irq}, 32'h1);
    // R7: level held while idle
    repeat (5) @(negedge clk);
    check("R7 level held", {30'b0, irq}, 32'h1);
    write(6'd41, 32'h0000_0100);
    @(negedge clk);
    check("R6 line1 quiet", {30'b0, irq}, 32'h1);
    write(6'd0, 32'h8000_0055);
    check("R6 old value", {30'b0, irq}, 32'h1);
    @(negedge clk);
    check("R2 full moves lines", {30'b0, irq}, 32'h2);
    write(6'd0, 32'h0000_0000);
    @(negedge clk);
    check("R3 empty moves lines", {30'b0, irq}, 32'h1);
    write(6'd2, 32'h0000_0000);
    @(negedge clk);
    check("R9 gate off", {30'b0, irq}, 32'h0);
    read_chk(6'd2, 32'h0, "R9 gate readback");

    // R1: reset mid-run
    write(6'd0, 32'h8000_0077);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 irq after reset", {30'b0, irq}, 32'h0);
    read_chk(6'd0, 32'h0, "R1 slot after reset");
    read_chk(6'd41, 32'h0, "R1 enable after reset");
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule